// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a single-clock static memory, 32 bits wide and split into four byte lanes, with a small depth set by a parameter. Every control and data input is captured on the rising clock edge. Each edge either loads a fresh word address from the pins or moves on inside the current burst. In a burst the low two address bits come from an internal 2-bit beat counter. A static order input chooses linear or interleaved order for that counter. A burst is optional: a new address may be loaded on every edge, with no idle cycle between loads.

Two active-low strobes start an access. The host-side strobe always starts a read, and any write controls in that cycle are ignored. The controller-side strobe starts a read or a write. The write address of a cycle is the address that cycle selects, and the data is stored at that same edge. Reads are flow-through: once an address is registered, the addressed word reaches the output through logic alone, with no extra register. The word written at an edge is therefore visible just after that edge.

Three chip enables (two active low, one active high) are examined only when a strobe is sampled. A strobe that finds the device unselected ends the current access. The output-enable and sleep inputs act asynchronously on the output. Sleep also freezes all state and blocks writes, and the stored contents are kept.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, until the first selected strobe, no access is active and `rdata` is 0.
- R2: A strobe (`pstb_n` or `cstb_n` low) sampled with the device selected (`ce0_n`=0, `ce1`=1, `ce2_n`=0) and `sleep` low registers `addr`. From just after that edge, `rdata` shows the word at `addr`.
- R3: In a burst, each edge with no strobe and `adv_n` low steps the 2-bit beat counter by one, modulo 4. With `adv_n` high the registered address is unchanged.
- R4: With `order_ilv`=0 (linear), beat k of a burst uses low address bits (s+k) mod 4, where s is the low two bits of the loaded address. The upper bits stay fixed.
- R5: With `order_ilv`=1 (interleaved), beat k uses low address bits s XOR k.
- R6: With `gw_n` high and `bw_n` low, only the byte lanes whose `ben_n` bit is low are written. Bit i of `ben_n` controls `wdata[8i+7:8i]`.
- R7: With `gw_n` low, all four byte lanes are written, whatever `bw_n` and `ben_n` are.
- R8: An edge on which `pstb_n` is low writes nothing, whatever the write controls are.
- R9: Strobes on consecutive edges, each with a different address, give the word at each new address in the cycle that follows its edge, with no lost cycle.
- R10: A strobe sampled with the device unselected writes nothing. It ends the access, and `rdata` is 0 until the next selected strobe.
- R11: While `sleep` is high, `rdata` is 0 at once, with no clock edge needed. No write, strobe or advance takes effect during sleep. After sleep is released, the same word as before is shown.
- R12: While `oe_n` is high, `rdata` is 0 at once, with no clock edge needed. The access state is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| addr | input | ADDR_W | Word address loaded by a strobe |
| wdata | input | 32 | Write data, four byte lanes |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| pstb_n | input | 1 | Host-side address strobe, read-only start, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ben_n | input | 4 | Per-lane write enables, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | 32 | Flow-through read data, 0 when idle |

## Verification
There are two kinds of result, and they are due at different times. The address, the write and the counter step all take effect at the rising edge that samples their inputs. The bench drives inputs at the falling edge, steps its behavioural model at the following rising edge, and compares `rdata` at the next falling edge, which is zero full cycles of latency. Output enable and sleep take effect within the same cycle. The bench changes them between edges and compares `rdata` one time unit later, without waiting for any edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // low address bits for beat 'step' of a burst that began at 'first'
    function automatic logic [1:0] beat_lo(input logic [1:0] first,
                                           input logic [1:0] step,
                                           input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_INTERLEAVE) r = first ^ step;
        else                       r = first + step;
        return r;
    endfunction

endpackage

// File: rtl/bsram_addr_map.sv
module bsram_addr_map
    import bsram_pkg::*;
(
    input  logic [1:0] first_lo,
    input  logic [1:0] step,
    input  logic       order_ilv,
    output logic [1:0] lo
);
    burst_order_e ord;

    always_comb begin
        ord = order_ilv ? ORD_INTERLEAVE : ORD_LINEAR;
        lo  = beat_lo(first_lo, step, ord);
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          wmask,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rword
);
    localparam int DEPTH = 1 << ADDR_W;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] cells [DEPTH];

            always_ff @(posedge clk) begin
                if (wmask[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end

            assign rword[g*LANE_W +: LANE_W] = cells[raddr];
        end
    endgenerate
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     ce0_n,
    input  logic                     ce1,
    input  logic                     ce2_n,
    input  logic                     pstb_n,
    input  logic                     cstb_n,
    input  logic                     adv_n,
    input  logic [LANES-1:0]         ben_n,
    input  logic                     bw_n,
    input  logic                     gw_n,
    input  logic                     order_ilv,
    input  logic                     oe_n,
    input  logic                     sleep,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int BEAT_W = 2;
    localparam int HIGH_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic                live;
        logic [ADDR_W-1:0]   base;
        logic [BEAT_W-1:0]   step;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic              selected, start, host_start, advance, access_ok;
    logic [BEAT_W-1:0] step_inc, cur_lo, inc_lo;
    logic [ADDR_W-1:0] rd_addr, eff_addr;
    logic [LANES-1:0]  lane_sel, wmask;
    logic [DATA_W-1:0] arr_word;

    assign step_inc = cur_q.step + 2'd1;

    bsram_addr_map u_cur (
        .first_lo (cur_q.base[BEAT_W-1:0]),
        .step     (cur_q.step),
        .order_ilv(order_ilv),
        .lo       (cur_lo)
    );

    bsram_addr_map u_inc (
        .first_lo (cur_q.base[BEAT_W-1:0]),
        .step     (step_inc),
        .order_ilv(order_ilv),
        .lo       (inc_lo)
    );

    assign rd_addr = {cur_q.base[ADDR_W-1 -: HIGH_W], cur_lo};

    always_comb begin
        nxt_d      = cur_q;
        selected   = !ce0_n && ce1 && !ce2_n;
        start      = !sleep && (!pstb_n || !cstb_n);
        host_start = start && !pstb_n;
        advance    = !sleep && !start && cur_q.live && !adv_n;
        eff_addr   = rd_addr;
        access_ok  = 1'b0;

        if (start) begin
            nxt_d.live = selected;
            nxt_d.base = addr;
            nxt_d.step = '0;
            eff_addr   = addr;
            access_ok  = selected && !host_start;
        end else if (!sleep && cur_q.live) begin
            access_ok = 1'b1;
            if (advance) begin
                nxt_d.step = step_inc;
                eff_addr   = {cur_q.base[ADDR_W-1 -: HIGH_W], inc_lo};
            end
        end

        if (!gw_n)      lane_sel = '1;
        else if (!bw_n) lane_sel = ~ben_n;
        else            lane_sel = '0;

        wmask = access_ok ? lane_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk  (clk),
        .wmask(wmask),
        .waddr(eff_addr),
        .wdata(wdata),
        .raddr(rd_addr),
        .rword(arr_word)
    );

    assign rdata = (cur_q.live && !oe_n && !sleep) ? arr_word : '0;

endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce0_n,
    input logic              ce1,
    input logic              ce2_n,
    input logic              pstb_n,
    input logic              cstb_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] rdata,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [LANES-1:0]  wmask
);
    a_r11_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> rdata == '0);

    a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> rdata == '0);

    a_r11_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(rd_addr));

    a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> wmask == '0);

    a_r3_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && cstb_n && adv_n) |=> $stable(rd_addr));

    a_r8_host_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !pstb_n |-> wmask == '0);

    a_r7_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && pstb_n && !cstb_n && !gw_n && !ce0_n && ce1 && !ce2_n)
        |-> wmask == '1);

    a_r10_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && pstb_n && !cstb_n && !ce1) |=> rdata == '0);

    a_r10_deselect_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!pstb_n || !cstb_n) && ce0_n) |-> wmask == '0);
endmodule

bind burst_sram bsram_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce0_n  (ce0_n),
    .ce1    (ce1),
    .ce2_n  (ce2_n),
    .pstb_n (pstb_n),
    .cstb_n (cstb_n),
    .adv_n  (adv_n),
    .gw_n   (gw_n),
    .oe_n   (oe_n),
    .sleep  (sleep),
    .rdata  (rdata),
    .rd_addr(rd_addr),
    .wmask  (wmask)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
    logic          pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic [3:0]    ben_n = 4'hF;
    logic          bw_n = 1'b1, gw_n = 1'b1, order_ilv = 1'b0;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic [31:0]   rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] mmem [DEPTH];
    bit          mvalid = 0;
    int          mbase = 0;
    int          mcnt = 0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .ben_n(ben_n), .bw_n(bw_n), .gw_n(gw_n), .order_ilv(order_ilv),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata)
    );

    function automatic int beat_index();
        int lo;
        if (order_ilv) lo = (mbase % 4) ^ mcnt;
        else           lo = ((mbase % 4) + mcnt) % 4;
        return (mbase / 4) * 4 + lo;
    endfunction

    function automatic logic [31:0] expect_rd();
        if (mvalid && !oe_n && !sleep) return mmem[beat_index()];
        return 32'h0;
    endfunction

    function automatic logic [31:0] pat(input int i);
        return 32'h3C00_0000 + i * 32'h0001_0203;
    endfunction

    task automatic store(input int idx);
        logic [3:0] m;
        if (!gw_n)      m = 4'hF;
        else if (!bw_n) m = ~ben_n;
        else            m = 4'h0;
        for (int b = 0; b < 4; b++)
            if (m[b]) mmem[idx][b*8 +: 8] = wdata[b*8 +: 8];
    endtask

    // model step at a rising edge, from the inputs then on the pins
    task automatic model_edge();
        bit sel, strt;
        sel  = !ce0_n && ce1 && !ce2_n;
        strt = !pstb_n || !cstb_n;
        if (!rst_n) begin
            mvalid = 0; mbase = 0; mcnt = 0;
        end else if (sleep) begin
        end else if (strt) begin
            if (sel && pstb_n) store(int'(addr));
            mvalid = sel; mbase = int'(addr); mcnt = 0;
        end else if (mvalid) begin
            if (!adv_n) mcnt = (mcnt + 1) % 4;
            store(beat_index());
        end
    endtask

    task automatic chk(input string tag);
        logic [31:0] e;
        e = expect_rd();
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h", tag, rdata, e);
        end
    endtask

    task automatic chk_val(input string tag, input logic [31:0] e);
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h", tag, rdata, e);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag);
    endtask

    task automatic idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; ben_n = 4'hF;
        ce0_n = 0; ce1 = 1; ce2_n = 0; sleep = 0; oe_n = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog rdata=%h expected=run completion", rdata);
        finish_run();
    end

    initial begin
        logic [31:0] old;
        // R1 reset
        repeat (3) cyc("R1 in reset");
        @(negedge clk);
        rst_n = 1;
        cyc("R1 after reset");
        chk_val("R1 idle output", 32'h0);

        // R2/R7 fill every word through the controller strobe
        for (int i = 0; i < DEPTH; i++) begin
            idle(); cstb_n = 0; gw_n = 0; addr = AW'(i); wdata = pat(i);
            cyc("R7 global fill");
        end
        idle(); pstb_n = 0; addr = 6'd33;
        cyc("R2 host strobe load");
        chk_val("R2 flow-through word", pat(33));

        // R4 linear burst from low bits 2: 6,7,4,5, wrap to 6
        order_ilv = 0;
        idle(); pstb_n = 0; addr = 6'd6; cyc("R4 start");
        chk_val("R4 beat0", pat(6));
        idle(); adv_n = 0; cyc("R4 beat1"); chk_val("R4 beat1 value", pat(7));
        cyc("R4 beat2"); chk_val("R4 beat2 value", pat(4));
        cyc("R4 beat3"); chk_val("R4 beat3 value", pat(5));
        cyc("R3 wrap"); chk_val("R3 counter wraps", pat(6));
        // R3 hold without advance
        idle(); cyc("R3 hold"); cyc("R3 hold"); chk_val("R3 held", pat(6));

        // R5 interleaved from low bits 1: 9,8,11,10
        order_ilv = 1;
        idle(); cstb_n = 0; addr = 6'd9; cyc("R5 start");
        chk_val("R5 beat0", pat(9));
        idle(); adv_n = 0; cyc("R5 beat1"); chk_val("R5 beat1 value", pat(8));
        cyc("R5 beat2"); chk_val("R5 beat2 value", pat(11));
        cyc("R5 beat3"); chk_val("R5 beat3 value", pat(10));
        order_ilv = 0;

        // R6 byte write: lanes 0 and 2
        idle(); cstb_n = 0; addr = 6'd20; bw_n = 0; ben_n = 4'b1010;
        wdata = 32'hDEAD_BEEF; cyc("R6 byte write");
        chk_val("R6 lanes 0 and 2", (pat(20) & 32'hFF00_FF00) | 32'h00AD_00EF);
        // R6 byte write on a burst beat (advance to 21, lane 3 only)
        idle(); adv_n = 0; bw_n = 0; ben_n = 4'b0111; wdata = 32'h5500_0000;
        cyc("R6 burst byte write");
        chk_val("R6 lane 3 on beat", (pat(21) & 32'h00FF_FFFF) | 32'h5500_0000);
        // R6 byte-write enable high: nothing written
        idle(); ben_n = 4'h0; wdata = 32'h0; cyc("R6 no bw");
        chk_val("R6 bw off", (pat(21) & 32'h00FF_FFFF) | 32'h5500_0000);

        // R7 global overrides per-lane enables
        idle(); cstb_n = 0; addr = 6'd40; gw_n = 0; bw_n = 0; ben_n = 4'hF;
        wdata = 32'h1234_5678; cyc("R7 global over lanes");
        chk_val("R7 all lanes", 32'h1234_5678);

        // R8 host strobe ignores write controls
        idle(); pstb_n = 0; cstb_n = 0; addr = 6'd41; gw_n = 0; wdata = 32'hFFFF_FFFF;
        cyc("R8 host strobe");
        chk_val("R8 no write", pat(41));

        // R9 new address every edge
        for (int k = 0; k < 6; k++) begin
            idle(); cstb_n = 0; addr = AW'(50 + k);
            cyc("R9 back to back");
            chk_val("R9 each cycle", pat(50 + k));
        end

        // R10 deselected strobe
        idle(); cstb_n = 0; ce1 = 0; addr = 6'd12; gw_n = 0; wdata = 32'h0BAD_0BAD;
        cyc("R10 deselect");
        chk_val("R10 idle output", 32'h0);
        idle(); adv_n = 0; gw_n = 0; cyc("R10 no beat");
        idle(); pstb_n = 0; addr = 6'd12; cyc("R10 reselect");
        chk_val("R10 word kept", pat(12));

        // R11 sleep
        idle(); pstb_n = 0; addr = 6'd30; cyc("R11 setup");
        sleep = 1; #1; chk_val("R11 async idle", 32'h0);
        cstb_n = 0; addr = 6'd31; gw_n = 0; wdata = 32'hCAFE_F00D; adv_n = 0;
        cyc("R11 during sleep");
        cyc("R11 during sleep");
        idle(); #1; chk_val("R11 word after wake", pat(30));
        idle(); pstb_n = 0; addr = 6'd31; cyc("R11 no write in sleep");
        chk_val("R11 contents kept", pat(31));

        // R12 output enable
        old = rdata;
        oe_n = 1; #1; chk_val("R12 async idle", 32'h0);
        pstb_n = 1; cyc("R12 oe high");
        oe_n = 0; #1; chk_val("R12 restored", old);

        idle(); cyc("final");
        finish_run();
    end
endmodule